// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer Controller

This controller connects a host that presents a flat 16-bit word address to a 64K x 1 DRAM whose address pins carry only 8 bits. The host issues one request at a time: a read or write strobe together with the address and, for writes, one data bit. The controller first places the upper address byte on the shared pins and drops the active-low row strobe. It then places the lower byte on the same pins and drops the active-low column strobe. The data bit is moved while the column strobe is low.

A write raises the row strobe while the column strobe is still low, so the device writes the modified row back. The column strobe and the write strobe then rise together to close the cycle. A read captures the device output while the column strobe is low, then raises both strobes together. Each access ends with a precharge gap. After the gap the controller pulses `done_o`, and for reads it presents the captured bit on `rdata_o`.

The lengths of the row and column phases and of the precharge gap are parameters, each at least one clock. This lets the same block meet a tight access budget, such as a 20 ns host period, or a slower device.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row address is `addr_i[15:8]` and appears on `dram_addr_o` when the row strobe falls. The column address is `addr_i[7:0]` and appears on `dram_addr_o` when the column strobe falls.
- R2: `dram_addr_o` holds the same value for at least one full clock before any falling edge of the row strobe or the column strobe.
- R3: A read keeps the write strobe high throughout. The column strobe falls only while the row strobe is low. The bit on `dram_dout_i` is sampled in the last clock with the column strobe low. The row strobe and the column strobe rise on the same clock. `rdata_o` holds the sampled bit when `done_o` is high.
- R4: A write runs in this order: the row strobe falls, the write strobe falls, the column strobe falls, the row strobe rises while the column strobe is still low, and finally the column strobe rises while the row strobe is high.
- R5: The row strobe stays low for T_RAS clocks before the column address is placed. The column strobe stays low for T_CAS clocks on a read and for 2*T_CAS clocks on a write. With the defaults T_RAS=2 and T_CAS=2, the row strobe is low for 5 clocks in both a read and a write.
- R6: After the row strobe rises, it stays high for at least T_PRE clocks before it can fall again. This holds even when requests arrive back to back.
- R7: `busy_o` goes high on the clock that accepts a request and stays high until the clock on which `done_o` goes high, when it falls. `done_o` is high for exactly one clock. Counting the accepting clock edge as edge 1, `done_o` appears after edge 3+T_RAS+T_CAS+T_PRE for a read (8 with the defaults) and after edge 3+T_RAS+2*T_CAS+T_PRE for a write (10 with the defaults).
- R8: A request presented while `busy_o` is high is ignored. It starts no access, and its address and data have no effect on the stored contents.
- R9: After reset, the row, column and write strobes are all high, `busy_o` is low and `done_o` is low.
- R10: During a write, `dram_din_o` carries `wdata_i`, as captured at acceptance, when the column strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, sampled when not busy |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Flat word address, row half in the upper byte |
| wdata_i | input | 1 | Write data bit |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock pulse when an access ends |
| rdata_o | output | 1 | Read data, valid when done_o is high after a read |
| dram_addr_o | output | 8 | Shared row/column address pins |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_din_o | output | 1 | Data bit toward the device |
| dram_dout_i | input | 1 | Data bit from the device |

## Verification
A wrong phase state or a corrupted phase counter shows up at the pins within one or two clocks. It appears as a strobe edge out of order, a strobe held low for the wrong number of clocks, or an address that changes on the same edge as a strobe fall. A behavioural device model in the bench watches every strobe edge at the falling clock edge, so these faults are flagged during the access in which they happen. A swapped or corrupted address half, or a mis-timed data sample, does not disturb the pins. It shows only when the bit is read back, and the bench catches it by reading back addresses whose row and column bytes differ.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ROW_SETUP,
        PH_ROW,
        PH_COL_SETUP,
        PH_COL,
        PH_WRITE_BACK,
        PH_PRECHARGE
    } phase_e;

endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = len_i - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == '0);

    // R5: a loaded phase never ends in the clock right after the load unless its length is one
    a_r5_load_len: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i > CNT_W'(1)) |=> !last_o);

endmodule

// File: rtl/dram_addr_sel.sv
module dram_addr_sel #(
    parameter int PIN_W = 8,
    localparam int ADDR_W = 2 * PIN_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              col_sel_i,
    output logic [PIN_W-1:0]  pins_o
);
    always_comb begin
        if (col_sel_i) pins_o = addr_i[PIN_W-1:0];
        else           pins_o = addr_i[ADDR_W-1:PIN_W];
    end
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_mux_pkg::*;
#(
    parameter int PIN_W = 8,
    parameter int T_RAS = 2,
    parameter int T_CAS = 2,
    parameter int T_PRE = 1,
    localparam int ADDR_W = 2 * PIN_W,
    localparam int MAX_PH = (T_RAS > T_CAS) ? ((T_RAS > T_PRE) ? T_RAS : T_PRE)
                                            : ((T_CAS > T_PRE) ? T_CAS : T_PRE),
    localparam int CNT_W = $clog2(MAX_PH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rdata_o,
    output logic [PIN_W-1:0]  dram_addr_o,
    output logic              dram_ras_n_o,
    output logic              dram_cas_n_o,
    output logic              dram_we_n_o,
    output logic              dram_din_o,
    input  logic              dram_dout_i
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              wd;
        logic              col_sel;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              din;
        logic              rdata;
        logic              done;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;

    dram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    dram_addr_sel #(.PIN_W(PIN_W)) u_addr_sel (
        .addr_i    (st_q.addr),
        .col_sel_i (st_q.col_sel),
        .pins_o    (dram_addr_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_len   = CNT_W'(1);
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.ph   = PH_ROW_SETUP;
                    st_d.addr = addr_i;
                    st_d.wr   = we_i;
                    st_d.wd   = wdata_i;
                end
            end
            PH_ROW_SETUP: begin
                st_d.ph  = PH_ROW;
                tmr_load = 1'b1;
                tmr_len  = CNT_W'(T_RAS);
            end
            PH_ROW: begin
                if (tmr_last) st_d.ph = PH_COL_SETUP;
            end
            PH_COL_SETUP: begin
                st_d.ph  = PH_COL;
                tmr_load = 1'b1;
                tmr_len  = CNT_W'(T_CAS);
            end
            PH_COL: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (st_q.wr) begin
                        st_d.ph = PH_WRITE_BACK;
                        tmr_len = CNT_W'(T_CAS);
                    end else begin
                        st_d.ph    = PH_PRECHARGE;
                        st_d.rdata = dram_dout_i;
                        tmr_len    = CNT_W'(T_PRE);
                    end
                end
            end
            PH_WRITE_BACK: begin
                if (tmr_last) begin
                    st_d.ph  = PH_PRECHARGE;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(T_PRE);
                end
            end
            PH_PRECHARGE: begin
                if (tmr_last) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase

        // pin levels follow the phase being entered, so every pin leaves a flop
        st_d.ras_n   = !(st_d.ph inside {PH_ROW, PH_COL_SETUP, PH_COL});
        st_d.cas_n   = !(st_d.ph inside {PH_COL, PH_WRITE_BACK});
        st_d.we_n    = !(st_d.wr && (st_d.ph inside {PH_COL_SETUP, PH_COL, PH_WRITE_BACK}));
        st_d.col_sel = st_d.ph inside {PH_COL_SETUP, PH_COL, PH_WRITE_BACK, PH_PRECHARGE};
        st_d.din     = st_d.wr && st_d.wd && (st_d.ph inside {PH_COL_SETUP, PH_COL, PH_WRITE_BACK});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ph    <= PH_IDLE;
            st_q.ras_n <= 1'b1;
            st_q.cas_n <= 1'b1;
            st_q.we_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o       = (st_q.ph != PH_IDLE);
    assign done_o       = st_q.done;
    assign rdata_o      = st_q.rdata;
    assign dram_ras_n_o = st_q.ras_n;
    assign dram_cas_n_o = st_q.cas_n;
    assign dram_we_n_o  = st_q.we_n;
    assign dram_din_o   = st_q.din;

    // R2: address pins unchanged on the edge where a strobe falls
    a_r2_row_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n_o) |-> $stable(dram_addr_o));
    a_r2_col_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n_o) |-> $stable(dram_addr_o));
    // R3: column strobe only falls inside an open row
    a_r3_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n_o) |-> !dram_ras_n_o);
    // R4: write strobe falls after the row opens and before the column strobe
    a_r4_we_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_we_n_o) |-> (!dram_ras_n_o && dram_cas_n_o));
    // R4: column strobe never outlives a closed row in the wrong order
    a_r4_cas_rise_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n_o) |-> dram_ras_n_o);
    // R6: at least one clock of precharge after the row closes
    a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n_o) |=> dram_ras_n_o);
    // R7: busy only starts from a request, done lasts one clock and ends busy
    a_r7_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i));
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

endmodule

// File: tb/sim_dram_mux_ctrl.sv
module sim_dram_mux_ctrl;
    localparam int T_RAS = 2;
    localparam int T_CAS = 2;
    localparam int T_PRE = 1;
    localparam int RD_LAT = 3 + T_RAS + T_CAS + T_PRE;
    localparam int WR_LAT = 3 + T_RAS + 2 * T_CAS + T_PRE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0, wd = 1'b0;
    logic [15:0] addr = '0;
    logic busy, done, rdata, ras_n, cas_n, we_n, din, dout;
    logic [7:0] pins;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dram_mux_ctrl #(.PIN_W(8), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_PRE(T_PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wd),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .dram_addr_o(pins),
        .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
        .dram_din_o(din), .dram_dout_i(dout)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural device model and edge monitor ----------------
    bit mem [int];
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    logic [7:0] p_pins = '0;
    logic [7:0] m_row = '0, m_col = '0;
    logic m_din = 1'b0;
    int step = 0;
    bit wr_cyc = 0;
    int mon_err = 0;
    int ras_low_cnt = 0, cas_low_cnt = 0, ras_hi_cnt = 0;
    int last_ras_low = 0, last_cas_low = 0, min_hi = 1000;
    int ras_falls = 0;
    bit seen_access = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                ras_falls++;
                if (pins != p_pins) mon_err++;
                if (seen_access && ras_hi_cnt < min_hi) min_hi = ras_hi_cnt;
                seen_access = 1;
                m_row = pins;
                step = 1;
                wr_cyc = 0;
                ras_low_cnt = 0;
            end
            if (p_we && !we_n) begin
                if (!(step == 1 && !ras_n && cas_n)) mon_err++;
                step = 2;
                wr_cyc = 1;
            end
            if (p_cas && !cas_n) begin
                if (pins != p_pins || ras_n) mon_err++;
                m_col = pins;
                cas_low_cnt = 0;
                if (!we_n) begin
                    if (step != 2) mon_err++;
                    step = 3;
                    m_din = din;
                    mem[{m_row, m_col}] = din;
                end else begin
                    dout = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 1'b0;
                end
            end
            if (!p_ras && ras_n) begin
                last_ras_low = ras_low_cnt;
                ras_hi_cnt = 0;
                if (wr_cyc) begin
                    if (!(step == 3 && !cas_n)) mon_err++;
                    step = 4;
                end else if (!cas_n) mon_err++;
            end
            if (!p_cas && cas_n) begin
                last_cas_low = cas_low_cnt;
                dout = 1'b0;
                if (wr_cyc) begin
                    if (!(step == 4 && ras_n && we_n)) mon_err++;
                    step = 5;
                end
            end
            if (!ras_n) ras_low_cnt++; else ras_hi_cnt++;
            if (!cas_n) cas_low_cnt++;
            p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_pins = pins;
        end
    end

    // ---------------- access helper ----------------
    task automatic access(input bit w, input logic [15:0] a, input bit d,
                          output int lat, output bit rd);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wd = d;
        lat = 0;
        rd = 1'b0;
        while (lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) begin
                req = 1'b0;
                check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
            end
            if (done) begin
                rd = rdata;
                check(busy == 1'b0, "R7 busy low with done", int'(busy), 0);
                break;
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R7 done one clock", int'(done), 0);
    endtask

    task automatic t_reset();
        check(ras_n && cas_n && we_n, "R9 strobes high after reset", int'({ras_n, cas_n, we_n}), 7);
        check(!busy && !done, "R9 busy and done low", int'({busy, done}), 0);
    endtask

    task automatic t_write_read(input logic [15:0] a, input bit d);
        int lat;
        bit rd;
        int e0;
        e0 = mon_err;
        access(1'b1, a, d, lat, rd);
        check(lat == WR_LAT, "R7 write latency", lat, WR_LAT);
        check(step == 5, "R4 write edge order", step, 5);
        check(m_row == a[15:8], "R1 row on pins at row strobe", int'(m_row), int'(a[15:8]));
        check(m_col == a[7:0], "R1 column on pins at column strobe", int'(m_col), int'(a[7:0]));
        check(m_din == d, "R10 data at column strobe", int'(m_din), int'(d));
        check(last_ras_low == T_RAS + 1 + T_CAS, "R5 row low clocks write", last_ras_low, T_RAS + 1 + T_CAS);
        check(last_cas_low == 2 * T_CAS, "R5 column low clocks write", last_cas_low, 2 * T_CAS);
        access(1'b0, a, 1'b0, lat, rd);
        check(lat == RD_LAT, "R7 read latency", lat, RD_LAT);
        check(rd == d, "R3 read back data", int'(rd), int'(d));
        check(last_ras_low == T_RAS + 1 + T_CAS, "R5 row low clocks read", last_ras_low, T_RAS + 1 + T_CAS);
        check(last_cas_low == T_CAS, "R5 column low clocks read", last_cas_low, T_CAS);
        check(mon_err == e0, "R2 R3 strobe and address timing", mon_err - e0, 0);
    endtask

    task automatic t_ignore_busy();
        int lat;
        bit rd;
        int f0;
        access(1'b1, 16'h3344, 1'b0, lat, rd);
        access(1'b1, 16'h5566, 1'b0, lat, rd);
        f0 = ras_falls;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 16'h3344; wd = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        // R8: request while busy, aimed at a different address
        req = 1'b1; addr = 16'h5566; wd = 1'b1;
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
        check(ras_falls == f0 + 1, "R8 no access started while busy", ras_falls - f0, 1);
        check(!busy, "R8 idle after ignored request", int'(busy), 0);
        access(1'b0, 16'h5566, 1'b0, lat, rd);
        check(rd == 1'b0, "R8 ignored write left data", int'(rd), 0);
        access(1'b0, 16'h3344, 1'b0, lat, rd);
        check(rd == 1'b1, "R8 accepted write stored", int'(rd), 1);
    endtask

    task automatic t_back_to_back();
        min_hi = 1000;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 16'h00FF;
        repeat (3 * WR_LAT) @(negedge clk);
        req = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        check(min_hi >= T_PRE, "R6 precharge gap back to back", min_hi, T_PRE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_read(16'h12AB, 1'b1);
        t_write_read(16'hAB12, 1'b0);
        t_write_read(16'h0000, 1'b1);
        t_write_read(16'hFFFF, 1'b1);
        t_write_read(16'h12AB, 1'b0);
        t_ignore_busy();
        t_back_to_back();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule